// File: doc/BRIEF.md
# Pin Change Interrupt Controller

This block turns the input pins of an 8-bit expander port into one interrupt line. Every pin has its own trigger rule. In change mode the pin fires when its value differs from the value it had one cycle earlier. In compare mode it fires for as long as it differs from a programmed reference bit. Compare mode is how a level trigger is built: set the mode bit, then load the reference with the idle level, which is the opposite of the level that should fire.

When the first enabled pin fires, the block records two things: which enabled pins caused the interrupt, and a snapshot of the whole port. Both records then stay frozen until software acknowledges the interrupt. The acknowledge is a read strobe. A configuration bit selects whether a read of the port or a read of the snapshot clears the interrupt. The interrupt line can be driven push-pull with either polarity, or as an open-drain output that only ever pulls low. The register file and the bus interface sit outside this block; they supply the configuration and the read strobes.

Top module: `pin_change_irq`

## Requirements
- R1: A pin whose bit in `irq_en` is 0 never causes an interrupt and never appears in `flag_q`, whatever its mode or activity.
- R2: An enabled pin whose `cmp_mode` bit is 0 raises an interrupt on each rising and each falling change of its synchronized value. A pin that stays at a constant value raises nothing.
- R3: An enabled pin whose `cmp_mode` bit is 1 raises an interrupt while its synchronized value differs from its bit in `ref_val`. While the mismatch persists, the interrupt re-arms immediately after every clear. A pin that matches its reference raises nothing.
- R4: When the interrupt becomes pending, `flag_q` holds exactly the enabled pins that fired in that cycle, and `cap_q` holds the synchronized port value of that cycle.
- R5: While the interrupt is pending and not cleared, `flag_q` and `cap_q` stay unchanged, even when the pins change. A change-mode event that arrives during this time is not kept.
- R6: With `cfg_clr_on_cap` = 0, a pulse on `rd_port` clears the pending interrupt and `rd_cap` has no effect. With `cfg_clr_on_cap` = 1, the roles of the two strobes are swapped. A clear resets `flag_q` to 0.
- R7: If a clear happens in the same cycle as a new event, the interrupt stays pending without a gap. In that case `flag_q` and `cap_q` are reloaded with the new event and the current port value.
- R8: Pad encoding. With `cfg_open_drain` = 1, `irq_o` = 0 and `irq_oe` equals the pending state. With `cfg_open_drain` = 0, `irq_oe` = 1 and `irq_o` = pending when `cfg_active_high` = 1, or `irq_o` = NOT pending when `cfg_active_high` = 0.
- R9: A pin change applied before a rising clock edge shows up on `irq_o`, `flag_q` and `cap_q` after the third rising edge, and not after the second. `port_q` shows the new value after the second edge.
- R10: While `rst` is high, `irq_oe`, `irq_o`, `flag_q` and `cap_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_in | input | 8 | Asynchronous pin values |
| irq_en | input | 8 | Per-pin interrupt enable |
| cmp_mode | input | 8 | Per-pin trigger rule: 0 = change from previous value, 1 = mismatch with reference |
| ref_val | input | 8 | Per-pin reference value for compare mode |
| cfg_clr_on_cap | input | 1 | 1: the capture read clears the interrupt; 0: the port read clears it |
| cfg_active_high | input | 1 | Push-pull polarity: 1 = active high |
| cfg_open_drain | input | 1 | 1: open-drain output, pulls low only |
| rd_port | input | 1 | One-cycle strobe for a port read |
| rd_cap | input | 1 | One-cycle strobe for a capture read |
| port_q | output | 8 | Synchronized port value |
| flag_q | output | 8 | Pins that caused the pending interrupt |
| cap_q | output | 8 | Port snapshot taken when the interrupt was raised |
| irq_o | output | 1 | Interrupt pad output value |
| irq_oe | output | 1 | Interrupt pad output enable |

## Verification
The hardest situation to reach from the ports is a clear that lands in the same cycle as a fresh event, because change-mode events last only one cycle. The bench reaches it with compare mode: a persistent mismatch makes an event exist in every cycle, so any read strobe coincides with one. Before that read, the bench changes the pins while the interrupt is pending. This shows two things: the records stay frozen while pending, and the re-armed snapshot picks up the new port value without the line ever dropping. Separate sweeps cover every pin under both enable states, both trigger rules and all four reference/pin combinations.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  // Returns {output_enable, output_value} for the interrupt pad.
  function automatic logic [1:0] pad_encode(input logic pend,
                                            input logic active_high,
                                            input logic open_drain);
    logic [1:0] r;
    if (open_drain) r = {pend, 1'b0};
    else            r = {1'b1, active_high ? pend : ~pend};
    return r;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[k] <= '0;
      else     stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pin_event_detect.sv
module pin_event_detect #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_s,
  input  logic [WIDTH-1:0] irq_en,
  input  logic [WIDTH-1:0] cmp_mode,
  input  logic [WIDTH-1:0] ref_val,
  output logic [WIDTH-1:0] hit
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pin_s;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_comb begin
      if (cmp_mode[i]) hit[i] = irq_en[i] & (pin_s[i] ^ ref_val[i]);
      else             hit[i] = irq_en[i] & (pin_s[i] ^ prev_q[i]);
    end
  end

  // R1: disabled pins never report
  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (hit & ~irq_en) == '0);

  // R2: a change-mode pin that held its value in the last cycle stays quiet
  a_r2_static_quiet: assert property (@(posedge clk) disable iff (rst)
    ($stable(pin_s) && $past(!rst)) |-> ((hit & ~cmp_mode) == '0));
endmodule

// File: rtl/pin_capture.sv
module pin_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] hit,
  input  logic [WIDTH-1:0] pin_s,
  input  logic             cfg_clr_on_cap,
  input  logic             rd_port,
  input  logic             rd_cap,
  output logic             pending_nxt,
  output logic [WIDTH-1:0] flag_q,
  output logic [WIDTH-1:0] cap_q
);
  logic pending_q;
  logic clr;
  logic arm;

  assign clr         = cfg_clr_on_cap ? rd_cap : rd_port;
  assign arm         = !pending_q || clr;
  assign pending_nxt = arm ? (|hit) : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      flag_q    <= '0;
      cap_q     <= '0;
    end else begin
      pending_q <= pending_nxt;
      if (arm) begin
        flag_q <= hit;
        if (|hit) cap_q <= pin_s;
      end
    end
  end

  // R4: pending always carries at least one cause, idle carries none
  a_r4_flag_consistent: assert property (@(posedge clk) disable iff (rst)
    pending_q ? (flag_q != '0) : (flag_q == '0));

  // R4: snapshot taken in the raising cycle
  a_r4_snapshot: assert property (@(posedge clk) disable iff (rst)
    (!pending_q && hit != '0) |=> (pending_q && cap_q == $past(pin_s)));

  // R5: records frozen while pending and not cleared
  a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
    (pending_q && !clr) |=> ($stable(flag_q) && $stable(cap_q) && pending_q));

  // R6: clear with no new event drops the interrupt
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (pending_q && clr && hit == '0) |=> !pending_q);

  // R7: clear with a coincident event stays pending
  a_r7_rearm: assert property (@(posedge clk) disable iff (rst)
    (pending_q && clr && hit != '0) |=> (pending_q && flag_q == $past(hit)));
endmodule

// File: rtl/pin_irq_pad.sv
module pin_irq_pad (
  input  logic clk,
  input  logic rst,
  input  logic pending_nxt,
  input  logic cfg_active_high,
  input  logic cfg_open_drain,
  output logic irq_o,
  output logic irq_oe
);
  import pin_irq_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) {irq_oe, irq_o} <= 2'b00;
    else     {irq_oe, irq_o} <= pad_encode(pending_nxt, cfg_active_high, cfg_open_drain);
  end

  // R8: open drain never drives high
  a_r8_od_low: assert property (@(posedge clk) disable iff (rst)
    cfg_open_drain |=> !irq_o);

  // R8: push-pull always drives
  a_r8_pp_drive: assert property (@(posedge clk) disable iff (rst)
    !cfg_open_drain |=> irq_oe);
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pins_in,
  input  logic [WIDTH-1:0] irq_en,
  input  logic [WIDTH-1:0] cmp_mode,
  input  logic [WIDTH-1:0] ref_val,
  input  logic             cfg_clr_on_cap,
  input  logic             cfg_active_high,
  input  logic             cfg_open_drain,
  input  logic             rd_port,
  input  logic             rd_cap,
  output logic [WIDTH-1:0] port_q,
  output logic [WIDTH-1:0] flag_q,
  output logic [WIDTH-1:0] cap_q,
  output logic             irq_o,
  output logic             irq_oe
);
  logic [WIDTH-1:0] pin_s;
  logic [WIDTH-1:0] hit;
  logic             pending_nxt;

  pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pins_in), .q(pin_s));

  pin_event_detect #(.WIDTH(WIDTH)) u_detect (
    .clk(clk), .rst(rst), .pin_s(pin_s), .irq_en(irq_en),
    .cmp_mode(cmp_mode), .ref_val(ref_val), .hit(hit));

  pin_capture #(.WIDTH(WIDTH)) u_capture (
    .clk(clk), .rst(rst), .hit(hit), .pin_s(pin_s),
    .cfg_clr_on_cap(cfg_clr_on_cap), .rd_port(rd_port), .rd_cap(rd_cap),
    .pending_nxt(pending_nxt), .flag_q(flag_q), .cap_q(cap_q));

  pin_irq_pad u_pad (
    .clk(clk), .rst(rst), .pending_nxt(pending_nxt),
    .cfg_active_high(cfg_active_high), .cfg_open_drain(cfg_open_drain),
    .irq_o(irq_o), .irq_oe(irq_oe));

  assign port_q = pin_s;
endmodule

// File: tb/pin_change_irq_test.sv
`timescale 1ns/1ps
module pin_change_irq_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst;
  logic [W-1:0] pins_in, irq_en, cmp_mode, ref_val;
  logic         cfg_clr_on_cap, cfg_active_high, cfg_open_drain;
  logic         rd_port, rd_cap;
  logic [W-1:0] port_q, flag_q, cap_q;
  logic         irq_o, irq_oe;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  pin_change_irq #(.WIDTH(W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .pins_in(pins_in), .irq_en(irq_en),
    .cmp_mode(cmp_mode), .ref_val(ref_val), .cfg_clr_on_cap(cfg_clr_on_cap),
    .cfg_active_high(cfg_active_high), .cfg_open_drain(cfg_open_drain),
    .rd_port(rd_port), .rd_cap(rd_cap), .port_q(port_q), .flag_q(flag_q),
    .cap_q(cap_q), .irq_o(irq_o), .irq_oe(irq_oe));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input bit cap);
    if (cap) rd_cap = 1'b1; else rd_port = 1'b1;
    tick(1);
    rd_cap = 1'b0; rd_port = 1'b0;
  endtask

  // pulse both strobes after settling: clears whatever is pending
  task automatic drain();
    tick(4);
    rd_cap = 1'b1; rd_port = 1'b1;
    tick(1);
    rd_cap = 1'b0; rd_port = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pins_in = '0; irq_en = '0; cmp_mode = '0; ref_val = '0;
    cfg_clr_on_cap = 1'b0; cfg_active_high = 1'b1; cfg_open_drain = 1'b0;
    rd_port = 1'b0; rd_cap = 1'b0;
    tick(3);
    chk("R10 reset oe", irq_oe, 0);
    chk("R10 reset o", irq_o, 0);
    chk("R10 reset flag", flag_q, 0);
    chk("R10 reset cap", cap_q, 0);
    rst = 1'b0;
    tick(4);
    chk("R10 idle after reset", {irq_oe, irq_o}, 2'b10);

    // R9 latency
    irq_en = 8'hFF;
    pins_in = 8'h01;
    tick(1);
    tick(1);
    chk("R9 port after 2 edges", port_q, 8'h01);
    chk("R9 no irq after 2 edges", irq_o, 0);
    tick(1);
    chk("R9 irq after 3 edges", irq_o, 1);
    chk("R9 flag after 3 edges", flag_q, 8'h01);
    chk("R9 cap after 3 edges", cap_q, 8'h01);
    rd(0);
    pins_in = 8'h00;
    drain();

    // R1/R2 sweep: each pin, enabled or only others enabled, both edges
    for (int i = 0; i < W; i++) begin
      for (int e = 0; e < 2; e++) begin
        logic [W-1:0] m;
        m = 8'(1 << i);
        irq_en = e ? m : ~m;
        cmp_mode = '0;
        pins_in = m;
        tick(4);
        chk(e ? "R2 rise irq" : "R1 disabled rise", irq_o, e);
        chk(e ? "R2 rise flag" : "R1 disabled flag", flag_q, e ? m : 8'h00);
        if (e) chk("R4 rise cap", cap_q, m);
        rd(0);
        chk("R6 port read clears", irq_o, 0);
        tick(3);
        chk("R2 constant pin quiet", irq_o, 0);
        pins_in = '0;
        tick(4);
        chk(e ? "R2 fall irq" : "R1 disabled fall", irq_o, e);
        if (e) chk("R4 fall cap", cap_q, 8'h00);
        rd(0);
        chk("R6 flag cleared", flag_q, 0);
      end
    end

    // R4 multi-pin: only enabled pins appear, whole port captured
    irq_en = 8'h0F; pins_in = 8'h5A;
    tick(4);
    chk("R4 multi flag", flag_q, 8'h0A);
    chk("R4 multi cap", cap_q, 8'h5A);
    rd(0);
    pins_in = 8'h00;
    tick(4);
    chk("R4 multi fall flag", flag_q, 8'h0A);
    chk("R4 multi fall cap", cap_q, 8'h00);
    rd(0);

    // R5 freeze; change-mode event during pending is dropped
    irq_en = 8'hFF; pins_in = 8'h01;
    tick(4);
    pins_in = 8'h03;
    tick(4);
    chk("R5 frozen flag", flag_q, 8'h01);
    chk("R5 frozen cap", cap_q, 8'h01);
    rd(0);
    chk("R5 dropped event", irq_o, 0);
    pins_in = 8'h00;
    drain();

    // R3 compare sweep over every pin and every pin/reference pair
    cmp_mode = 8'hFF; irq_en = 8'hFF;
    for (int i = 0; i < W; i++) begin
      for (int c = 0; c < 4; c++) begin
        logic [W-1:0] pv, rv;
        pv = (c & 1) ? 8'(1 << i) : 8'h00;
        rv = (c & 2) ? 8'(1 << i) : 8'h00;
        pins_in = pv; ref_val = rv;
        tick(4);
        rd(0);
        chk("R3 compare pending", irq_o, (pv != rv));
        chk("R3 compare flag", flag_q, pv ^ rv);
        if (pv != rv) chk("R3 rearm cap", cap_q, pv);
      end
    end
    pins_in = '0; ref_val = '0;
    drain();

    // R3 level trigger: fire while pin is low (reference 1)
    irq_en = 8'h04; ref_val = 8'h04; pins_in = 8'h04;
    drain();
    chk("R3 level idle quiet", irq_o, 0);
    pins_in = 8'h00;
    tick(4);
    chk("R3 level fires", irq_o, 1);
    rd(0);
    tick(2);
    chk("R3 level persists", irq_o, 1);
    pins_in = 8'h04;
    drain();
    chk("R3 level released", irq_o, 0);

    // R7 clear coinciding with event, after pins changed while frozen
    irq_en = 8'h81; ref_val = 8'h00; pins_in = 8'h01;
    tick(4);
    chk("R7 first flag", flag_q, 8'h01);
    pins_in = 8'h81;
    tick(4);
    chk("R7 frozen cap", cap_q, 8'h01);
    rd(0);
    chk("R7 no gap", irq_o, 1);
    chk("R7 new flag", flag_q, 8'h81);
    chk("R7 new cap", cap_q, 8'h81);
    pins_in = 8'h00;
    drain();
    chk("R7 released", irq_o, 0);

    // R6 clear-source selection
    cmp_mode = '0; irq_en = 8'hFF; cfg_clr_on_cap = 1'b1;
    pins_in = 8'h10;
    tick(4);
    rd(0);
    chk("R6 port read ignored irq", irq_o, 1);
    chk("R6 port read ignored flag", flag_q, 8'h10);
    rd(1);
    chk("R6 capture read clears", irq_o, 0);
    cfg_clr_on_cap = 1'b0;
    pins_in = 8'h00;
    tick(4);
    rd(1);
    chk("R6 capture read ignored", irq_o, 1);
    rd(0);
    chk("R6 port read clears again", irq_o, 0);

    // R8 pad encoding, all configurations, idle and pending
    for (int od = 0; od < 2; od++) begin
      for (int ah = 0; ah < 2; ah++) begin
        drain();
        cfg_open_drain = od[0]; cfg_active_high = ah[0];
        tick(2);
        chk("R8 idle pad", {irq_oe, irq_o}, od ? 2'b00 : {1'b1, ~ah[0]});
        pins_in = pins_in ^ 8'h20;
        tick(4);
        chk("R8 pending pad", {irq_oe, irq_o}, od ? 2'b10 : {1'b1, ah[0]});
      end
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule